// File: doc/BRIEF.md
# SPI Receive Word Checker

This block sits behind an SPI master's bit-timing logic and turns the serial bits of one transfer into a single 32-bit receive status word. A start pulse loads the settings for the word: character length, shift order, parity on or off, parity sense and chip-select number. After that, one sample strobe per bit supplies the received line value, the bit this device drove on its own output and the value read back from that output pin at the same sample point.

The checker rebuilds the data right-justified, whatever the length and shift order. It compares its own driven line with what the pin actually carried, to catch collisions and noise. It also checks an optional parity bit that follows the data. The sticky error flags, the chip-select number and the data are packed into one word, and a single-cycle done pulse marks the moment that word is valid. A read of the data field clears the error flags. The same own-line check serves a slave, which drives the opposite line. The clock generator, the buffer memory and interrupt routing sit elsewhere.

Top module: `spi_rx_word_checker`

## Requirements
- R1: At any accepted sample strobe, if the read-back own line differs from the bit that was driven, status bit 28 becomes 1 from the next cycle on and stays set.
- R2: When parity is enabled for a word, the sample after the last data bit is the parity bit. The expected value is the XOR of the data bits when even parity is chosen, or its inverse when odd parity is chosen. A mismatch sets status bit 26. Parity enable and parity sense are latched per word at the start pulse.
- R3: A 4-bit length field f selects f+1 data bits, and f = 0 selects 2 bits. With parity enabled the word takes exactly one extra sample.
- R4: Data appears in status bits 15..0, right-justified, and bits above the length are zero. In MSB-first order the first bit received is the most significant data bit. In LSB-first order it is bit 0.
- R5: Status bits 23..16 hold the chip-select number presented at the start pulse of the completed word.
- R6: A pulse on the desync, timeout or length-error event input sets status bit 27, 25 or 24 respectively, and the flag stays set. Bits 31..29 always read zero.
- R7: A read pulse clears bits 28..24 in the next cycle, while the data and chip-select fields stay unchanged. An event arriving in the same cycle as the read leaves its flag set.
- R8: The done output is high for exactly one cycle, in the cycle after the final sample strobe of the word. The data and chip-select fields take their new values on that same edge.
- R9: Sample strobes while no word is active have no effect on the status word or on done. A start pulse during a word discards the partial word and begins a new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| word_start | input | 1 | Begins a word and latches its settings |
| cfg_len | input | 4 | Character length field (f+1 bits, 0 gives 2) |
| cfg_lsb_first | input | 1 | 1 = LSB-first order |
| cfg_par_en | input | 1 | Parity bit follows the data |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even |
| cfg_cs | input | 8 | Chip-select number for this word |
| smp_stb | input | 1 | Receive-point sample strobe |
| rx_line | input | 1 | Received data line value |
| drv_bit | input | 1 | Bit this device drove for this slot |
| drv_line | input | 1 | Own output pin read back at the sample point |
| evt_desync | input | 1 | Desynchronization event pulse |
| evt_timeout | input | 1 | Enable timeout event pulse |
| evt_len_err | input | 1 | Data-length error event pulse |
| data_rd | input | 1 | Read of the data field, clears error flags |
| word_done | output | 1 | One-cycle pulse: status word valid |
| status_word | output | 32 | Flags, chip select and right-justified data |

## Verification
The bench builds the block with its default parameters: a 16-bit data field, an 8-bit chip-select field and a 4-bit length field. At that size every length code 0 through 15 can be swept with both shift orders and with parity off, even or odd. The sweep combines all-ones, all-zero and mixed data with injected own-line mismatches at varying bit positions and with flipped parity bits. The small width also makes it practical to confirm read-to-clear, event/read collisions, ignored idle strobes and a restart in mid-word against arithmetically computed status words.

// File: rtl/spi_rxchk_pkg.sv
package spi_rxchk_pkg;
  // Order of members matches status bits 28 down to 24.
  typedef struct packed {
    logic bit_err;
    logic desync;
    logic par_err;
    logic timeout;
    logic len_err;
  } rx_flags_t;

  localparam int FLAG_N = 5;
  localparam int PAD_N  = 3;
endpackage

// File: rtl/rxchk_shifter.sv
module rxchk_shifter #(
  parameter int DATA_W = 16,
  parameter int LEN_W  = 4,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [LEN_W-1:0]  len_field,
  input  logic              lsb_first,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              smp_stb,
  input  logic              rx_line,
  output logic              busy,
  output logic              acc_stb,
  output logic              par_stb,
  output logic              fin_stb,
  output logic              par_odd_q,
  output logic [CNT_W-1:0]  word_len,
  output logic [DATA_W-1:0] word_data
);
  logic              busy_q, lsb_q, par_q;
  logic [CNT_W-1:0]  cnt_q, len_q, last_idx;
  logic [DATA_W-1:0] sh_q;
  logic              data_stb;

  function automatic logic [CNT_W-1:0] eff_len(input logic [LEN_W-1:0] f);
    logic [CNT_W-1:0] r;
    r = CNT_W'(f) + CNT_W'(1);
    if (f == '0) r = CNT_W'(2);
    return r;
  endfunction

  function automatic logic [DATA_W-1:0] place_bit(input logic [DATA_W-1:0] cur,
                                                  input logic b,
                                                  input logic [CNT_W-1:0] idx,
                                                  input logic lsb);
    logic [DATA_W-1:0] r;
    if (lsb) r = cur | (DATA_W'(b) << idx);
    else     r = {cur[DATA_W-2:0], b};
    return r;
  endfunction

  assign acc_stb   = busy_q && smp_stb && !start;
  assign data_stb  = acc_stb && (cnt_q < len_q);
  assign par_stb   = acc_stb && par_q && (cnt_q == len_q);
  assign last_idx  = len_q + CNT_W'(par_q) - CNT_W'(1);
  assign fin_stb   = acc_stb && (cnt_q == last_idx);
  assign word_data = data_stb ? place_bit(sh_q, rx_line, cnt_q, lsb_q) : sh_q;
  assign busy      = busy_q;
  assign word_len  = len_q;
  assign par_odd_q = par_q ? par_odd_l : 1'b0;

  logic par_odd_l;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      lsb_q     <= 1'b0;
      par_q     <= 1'b0;
      par_odd_l <= 1'b0;
      cnt_q     <= '0;
      len_q     <= CNT_W'(2);
      sh_q      <= '0;
    end else if (start) begin
      busy_q    <= 1'b1;
      lsb_q     <= lsb_first;
      par_q     <= par_en;
      par_odd_l <= par_odd;
      cnt_q     <= '0;
      len_q     <= eff_len(len_field);
      sh_q      <= '0;
    end else if (acc_stb) begin
      sh_q  <= word_data;
      cnt_q <= cnt_q + CNT_W'(1);
      if (fin_stb) busy_q <= 1'b0;
    end
  end

  AST_IDLE_NO_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && !start) |=> $stable(sh_q)); // R9
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q <= last_idx)); // R3
endmodule

// File: rtl/rxchk_flags.sv
module rxchk_flags
  import spi_rxchk_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_stb,
  input  logic              drv_bit,
  input  logic              drv_line,
  input  logic              par_stb,
  input  logic              par_rx,
  input  logic              par_odd,
  input  logic [DATA_W-1:0] data_sofar,
  input  logic              evt_desync,
  input  logic              evt_timeout,
  input  logic              evt_len_err,
  input  logic              rd_clr,
  output rx_flags_t         flags
);
  rx_flags_t flg_q, set_v;
  logic      line_mis, par_mis, any_set;

  function automatic logic ref_parity(input logic [DATA_W-1:0] d, input logic odd);
    return (^d) ^ odd;
  endfunction

  assign line_mis = acc_stb && (drv_bit != drv_line);
  assign par_mis  = par_stb && (par_rx != ref_parity(data_sofar, par_odd));

  always_comb begin
    set_v.bit_err = line_mis;
    set_v.desync  = evt_desync;
    set_v.par_err = par_mis;
    set_v.timeout = evt_timeout;
    set_v.len_err = evt_len_err;
  end
  assign any_set = |set_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flg_q <= '0;
    else        flg_q <= set_v | (rd_clr ? rx_flags_t'('0) : flg_q);
  end

  assign flags = flg_q;

  AST_BITERR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    line_mis |=> flg_q.bit_err); // R1
  AST_PARERR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    par_mis |=> flg_q.par_err); // R2
  AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && !any_set) |=> (flg_q == '0)); // R7
  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_clr && flg_q.desync) |=> flg_q.desync); // R6
endmodule

// File: rtl/spi_rx_word_checker.sv
module spi_rx_word_checker
  import spi_rxchk_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CS_W   = 8,
  parameter int LEN_W  = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         word_start,
  input  logic [3:0]   cfg_len,
  input  logic         cfg_lsb_first,
  input  logic         cfg_par_en,
  input  logic         cfg_par_odd,
  input  logic [7:0]   cfg_cs,
  input  logic         smp_stb,
  input  logic         rx_line,
  input  logic         drv_bit,
  input  logic         drv_line,
  input  logic         evt_desync,
  input  logic         evt_timeout,
  input  logic         evt_len_err,
  input  logic         data_rd,
  output logic         word_done,
  output logic [31:0]  status_word
);
  localparam int CNT_W  = $clog2(DATA_W + 2);
  localparam int STAT_W = PAD_N + FLAG_N + CS_W + DATA_W;

  logic              busy, acc_stb, par_stb, fin_stb, par_odd_q;
  logic [CNT_W-1:0]  word_len;
  logic [DATA_W-1:0] word_data, data_out;
  logic [CS_W-1:0]   cs_q, cs_out;
  logic              done_q;
  rx_flags_t         flags;
  logic [STAT_W-1:0] stat_v;

  function automatic logic [DATA_W-1:0] len_mask(input logic [CNT_W-1:0] n);
    return DATA_W'(({(DATA_W+1){1'b1}} << n) >> 0) ^ {DATA_W{1'b1}};
  endfunction

  rxchk_shifter #(.DATA_W(DATA_W), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .start(word_start), .len_field(LEN_W'(cfg_len)),
    .lsb_first(cfg_lsb_first), .par_en(cfg_par_en), .par_odd(cfg_par_odd),
    .smp_stb(smp_stb), .rx_line(rx_line), .busy(busy), .acc_stb(acc_stb),
    .par_stb(par_stb), .fin_stb(fin_stb), .par_odd_q(par_odd_q),
    .word_len(word_len), .word_data(word_data)
  );

  rxchk_flags #(.DATA_W(DATA_W)) u_flags (
    .clk(clk), .rst_n(rst_n), .acc_stb(acc_stb), .drv_bit(drv_bit),
    .drv_line(drv_line), .par_stb(par_stb), .par_rx(rx_line),
    .par_odd(par_odd_q), .data_sofar(word_data), .evt_desync(evt_desync),
    .evt_timeout(evt_timeout), .evt_len_err(evt_len_err), .rd_clr(data_rd),
    .flags(flags)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q     <= '0;
      cs_out   <= '0;
      data_out <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= fin_stb;
      if (word_start) cs_q <= CS_W'(cfg_cs);
      if (fin_stb) begin
        cs_out   <= cs_q;
        data_out <= word_data;
      end
    end
  end

  assign stat_v      = {{PAD_N{1'b0}}, flags, cs_out, data_out};
  assign status_word = 32'(stat_v);
  assign word_done   = done_q;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R8
  AST_RJUST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> ((data_out & ~len_mask(word_len)) == '0)); // R4
  AST_DONE_AFTER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy); // R9
endmodule

// File: tb/spi_rx_word_checker_tb.sv
module spi_rx_word_checker_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        word_start = 0, cfg_lsb_first = 0, cfg_par_en = 0, cfg_par_odd = 0;
  logic [3:0]  cfg_len = '0;
  logic [7:0]  cfg_cs = '0;
  logic        smp_stb = 0, rx_line = 0, drv_bit = 0, drv_line = 0;
  logic        evt_desync = 0, evt_timeout = 0, evt_len_err = 0, data_rd = 0;
  logic        word_done;
  logic [31:0] status_word;
  int          n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_rx_word_checker dut_i (.*);

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Sends one word; returns the expected status word.
  task automatic send_word(input int f, input bit lsb, input int pmode,
                           input logic [15:0] data, input logic [7:0] cs,
                           input int err_idx, input bit par_flip,
                           output logic [31:0] exp);
    int L, total;
    logic [15:0] d;
    logic par;
    L = (f == 0) ? 2 : f + 1;
    d = data & 16'((32'h1 << L) - 1);
    total = L + ((pmode != 0) ? 1 : 0);
    par = (^d) ^ (pmode == 2) ^ par_flip;
    @(negedge clk);
    word_start = 1; cfg_len = 4'(f); cfg_lsb_first = lsb;
    cfg_par_en = (pmode != 0); cfg_par_odd = (pmode == 2); cfg_cs = cs;
    @(negedge clk);
    word_start = 0;
    for (int i = 0; i < total; i++) begin
      smp_stb = 1;
      if (i < L) rx_line = lsb ? d[i] : d[L-1-i];
      else       rx_line = par;
      drv_bit  = rx_line ^ 1'(i & 1);
      drv_line = drv_bit ^ (i == err_idx);
      @(negedge clk);
      smp_stb = 0;
    end
    exp = {3'b0, (err_idx >= 0 && err_idx < total), 1'b0,
           (pmode != 0 && par_flip), 2'b0, cs, d};
  endtask

  task automatic do_read();
    data_rd = 1;
    @(negedge clk);
    data_rd = 0;
  endtask

  initial begin
    repeat (20000 * 10) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] exp, prev;
    repeat (3) @(negedge clk);
    check({31'b0, word_done}, 32'h0, "R8 reset done");
    check(status_word, 32'h0, "R6 reset status");
    rst_n = 1;
    @(negedge clk);

    // Sweep: length x order x parity mode x pattern (R1 R2 R3 R4 R5 R8)
    for (int f = 0; f < 16; f++)
      for (int lsb = 0; lsb < 2; lsb++)
        for (int pm = 0; pm < 3; pm++)
          for (int p = 0; p < 4; p++) begin
            logic [15:0] d;
            int L, err;
            bit flip;
            L = (f == 0) ? 2 : f + 1;
            case (p)
              0: d = 16'hFFFF;
              1: d = 16'h0000;
              2: d = 16'hA5C3 ^ 16'(f * 16'h1357);
              default: d = 16'h3C96 ^ 16'(lsb * 16'h0F0F);
            endcase
            err  = (p == 2) ? (f % L) : ((p == 3) ? L - 1 + (pm != 0 ? 1 : 0) : -1);
            flip = (p >= 2);
            send_word(f, lsb[0], pm, d, 8'(f * 17 + p), err, flip, exp);
            check({31'b0, word_done}, 32'h1, "R8 done after last sample");
            check(status_word, exp, "R1/R2/R3/R4/R5 status word");
            @(negedge clk);
            check({31'b0, word_done}, 32'h0, "R8 done single cycle");
            do_read();
            check(status_word, exp & 32'h00FF_FFFF, "R7 flags cleared, fields kept");
          end

    // R9: idle samples ignored
    prev = status_word;
    smp_stb = 1; rx_line = 1; drv_bit = 1; drv_line = 0;
    @(negedge clk);
    @(negedge clk);
    smp_stb = 0;
    check({31'b0, word_done}, 32'h0, "R9 no done from idle strobes");
    check(status_word, prev, "R9 status unchanged by idle strobes");

    // R9: restart discards partial word
    @(negedge clk);
    word_start = 1; cfg_len = 4'd7; cfg_lsb_first = 0; cfg_par_en = 0; cfg_cs = 8'h11;
    @(negedge clk);
    word_start = 0;
    for (int i = 0; i < 3; i++) begin
      smp_stb = 1; rx_line = 1; drv_bit = 1; drv_line = 1;
      @(negedge clk);
      smp_stb = 0;
    end
    send_word(3, 1'b1, 0, 16'h000A, 8'h5E, -1, 1'b0, exp);
    check(status_word, exp, "R9 restart gives new word only");

    // R6: event flags and zero top bits
    evt_desync = 1;
    @(negedge clk);
    evt_desync = 0;
    check(status_word & 32'hF800_0000, 32'h0800_0000, "R6 desync bit 27");
    evt_len_err = 1;
    @(negedge clk);
    evt_len_err = 0;
    check(status_word & 32'hFF00_0000, 32'h0900_0000, "R6 length error bit 24 sticky");
    // R7: read with simultaneous timeout
    data_rd = 1; evt_timeout = 1;
    @(negedge clk);
    data_rd = 0; evt_timeout = 0;
    check(status_word & 32'hFF00_0000, 32'h0200_0000, "R7 event wins over read");
    check(status_word & 32'h00FF_FFFF, exp & 32'h00FF_FFFF, "R7 data kept after read");
    do_read();
    check(status_word, exp & 32'h00FF_FFFF, "R7 final clear");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule